// File: doc/BRIEF.md
# Interrupt Request and Vector Unit

This block turns a set of latched peripheral event flags into a single interrupt request for a CPU core. Each flag is held until software clears it. A flag counts only when its own enable bit is set. The combined request is then gated by a global enable, which the block owns, and by an overall enable input. The combined request passes through a short register pipeline, so the request to the core follows a flag change two cycles late. A software-interrupt line from the instruction decoder is a further source. It bypasses that pipeline.

The block keeps one vector address, which software writes a byte at a time, and one saved-PC register, which software reads a byte at a time. When the core takes an interrupt, the block drives the vector onto the PC-load port, captures the interrupted PC and clears the global enable. On return, it drives the saved PC back and sets the global enable again. A variant of the return also loads the vector with the address after the return instruction. Service routines placed back to back in memory can use this to run in round-robin order.

Top module: `irq_vector_unit`

## Requirements
- R1: A flag bit goes to 1 on the clock edge after its set bit is seen and stays 1 until its clear bit is seen. When set and clear arrive for the same bit in the same cycle, the flag ends up set.
- R2: The pipelined source request is the OR over all bits of (flag AND enable). The request output irq_o is low whenever int_en_i is low or the global enable is 0. A flag whose enable bit is 0 never raises irq_o.
- R3: With the enables open, irq_o rises after the third clock edge counted from the edge that sets the flag. irq_o stays high for two more cycles after the edge that clears the flag, and falls after the third edge.
- R4: swi_i raises irq_o in the same cycle, without the pipeline delay. It is still gated by int_en_i and the global enable.
- R5: While take_i is high, pc_we_o is 1 and pc_wdata_o equals the vector. After that edge, the saved PC equals pc_i, gie_o is 0 and irq_o is low.
- R6: While ret_i is high, pc_we_o is 1 and pc_wdata_o equals the saved PC. After that edge, gie_o is 1.
- R7: A return with ret_upd_i high loads the vector with ret_pc_i + 1, taken modulo 2^16, so 16'hFFFF gives 16'h0000.
- R8: vec_hi_we_i writes vec_wdata_i to vector bits [15:8] and vec_lo_we_i writes it to bits [7:0], each without touching the other byte. An updating return in the same cycle overrides both byte writes.
- R9: The sources are level-sensitive. If a request is still pending when a return completes, irq_o is high in the cycle right after the return edge.
- R10: After reset, all flags are 0, the vector is 0, the saved PC is 0, gie_o is 1 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set_i | input | NSRC | Peripheral event pulses, one bit per source |
| flag_clr_i | input | NSRC | Software clear mask for the flags |
| src_en_i | input | NSRC | Per-source enable bits |
| int_en_i | input | 1 | Overall interrupt enable |
| swi_i | input | 1 | Software interrupt instruction request |
| take_i | input | 1 | Core takes the interrupt this cycle |
| pc_i | input | 16 | PC of the interrupted instruction |
| ret_i | input | 1 | Return from interrupt this cycle |
| ret_upd_i | input | 1 | Return also rewrites the vector |
| ret_pc_i | input | 16 | Address of the return instruction |
| vec_hi_we_i | input | 1 | Write enable for the vector high byte |
| vec_lo_we_i | input | 1 | Write enable for the vector low byte |
| vec_wdata_i | input | 8 | Vector byte write data |
| irq_o | output | 1 | Interrupt request to the core |
| gie_o | output | 1 | Global enable state |
| pc_we_o | output | 1 | PC load strobe |
| pc_wdata_o | output | 16 | PC load value |
| ipc_hi_o | output | 8 | Saved PC high byte |
| ipc_lo_o | output | 8 | Saved PC low byte |

## Verification
A software write to a vector byte and an updating return can land in the same cycle. The bench provokes this by driving vec_hi_we_i with one byte while a return with ret_upd_i is in progress. It judges the outcome by the address presented on the next take, which must be the incremented return address and must not contain the written byte. The bench also raises set and clear for one flag bit in the same cycle and confirms that the request later asserts.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W;
  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flags_o
);
  logic [NSRC-1:0] flags_d, flags_q;

  // a set in the same cycle as a clear wins, so no event is lost
  always_comb flags_d = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;

  assign flags_o = flags_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(flags_o)); // R1
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R1
endmodule

// File: rtl/irq_req_pipe.sv
module irq_req_pipe #(
  parameter int NSRC = 8,
  parameter int LAG  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flags_i,
  input  logic [NSRC-1:0] en_i,
  output logic            pend_o
);
  logic           raw;
  logic [LAG-1:0] stage_d, stage_q;

  always_comb raw = |(flags_i & en_i);

  generate
    if (LAG == 1) begin : g_one
      always_comb stage_d = raw;
    end else begin : g_many
      always_comb stage_d = {stage_q[LAG-2:0], raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;

  assign pend_o = stage_q[LAG-1];

  AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage_q[0] == $past(raw))); // R3
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_i,
  input  pc_t   pc_i,
  input  logic  ret_i,
  input  logic  ret_upd_i,
  input  pc_t   ret_pc_i,
  input  logic  vec_hi_we_i,
  input  logic  vec_lo_we_i,
  input  byte_t vec_wdata_i,
  output logic  gie_o,
  output pc_t   ipc_o,
  output logic  pc_we_o,
  output pc_t   pc_wdata_o
);
  pc_t  vec_d, vec_q, ipc_d, ipc_q;
  logic gie_d, gie_q;
  logic ret_eff;

  // a take wins over a return in the same cycle
  assign ret_eff = ret_i & ~take_i;

  always_comb begin
    vec_d = vec_q;
    if (vec_hi_we_i) vec_d[PC_W-1:BYTE_W] = vec_wdata_i;
    if (vec_lo_we_i) vec_d[BYTE_W-1:0]    = vec_wdata_i;
    if (ret_eff && ret_upd_i) vec_d = ret_pc_i + PC_W'(1);
    ipc_d = take_i ? pc_i : ipc_q;
    gie_d = gie_q;
    if (take_i)       gie_d = 1'b0;
    else if (ret_eff) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vec_q <= '0;
      ipc_q <= '0;
      gie_q <= 1'b1;
    end else begin
      vec_q <= vec_d;
      ipc_q <= ipc_d;
      gie_q <= gie_d;
    end

  assign gie_o      = gie_q;
  assign ipc_o      = ipc_q;
  assign pc_we_o    = take_i | ret_i;
  assign pc_wdata_o = take_i ? vec_q : ipc_q;

  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !gie_o); // R5
  AST_TAKE_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (ipc_o == $past(pc_i))); // R5
  AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i) |=> gie_o); // R6
  AST_RET_VEC_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && ret_upd_i) |=> (vec_q == pc_t'($past(ret_pc_i) + PC_W'(1)))); // R7
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int REQ_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   flag_set_i,
  input  logic [NSRC-1:0]   flag_clr_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              int_en_i,
  input  logic              swi_i,
  input  logic              take_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              ret_i,
  input  logic              ret_upd_i,
  input  logic [PC_W-1:0]   ret_pc_i,
  input  logic              vec_hi_we_i,
  input  logic              vec_lo_we_i,
  input  logic [BYTE_W-1:0] vec_wdata_i,
  output logic              irq_o,
  output logic              gie_o,
  output logic              pc_we_o,
  output logic [PC_W-1:0]   pc_wdata_o,
  output logic [BYTE_W-1:0] ipc_hi_o,
  output logic [BYTE_W-1:0] ipc_lo_o
);
  logic [NSRC-1:0] flags;
  logic            pend;
  pc_t             ipc;

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set_i), .clr_i(flag_clr_i),
    .flags_o(flags)
  );

  irq_req_pipe #(.NSRC(NSRC), .LAG(REQ_LAG)) u_pipe (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .en_i(src_en_i),
    .pend_o(pend)
  );

  irq_vec_ctl u_vec (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .pc_i(pc_i),
    .ret_i(ret_i), .ret_upd_i(ret_upd_i), .ret_pc_i(ret_pc_i),
    .vec_hi_we_i(vec_hi_we_i), .vec_lo_we_i(vec_lo_we_i),
    .vec_wdata_i(vec_wdata_i), .gie_o(gie_o), .ipc_o(ipc),
    .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o)
  );

  assign irq_o    = (pend | swi_i) & gie_o & int_en_i;
  assign ipc_hi_o = ipc[PC_W-1:BYTE_W];
  assign ipc_lo_o = ipc[BYTE_W-1:0];

  AST_NO_IRQ_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !irq_o); // R5
endmodule

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] flag_set_i, flag_clr_i, src_en_i;
  logic int_en_i, swi_i, take_i, ret_i, ret_upd_i, vec_hi_we_i, vec_lo_we_i;
  logic [15:0] pc_i, ret_pc_i, pc_wdata_o;
  logic [7:0] vec_wdata_i, ipc_hi_o, ipc_lo_o;
  logic irq_o, gie_o, pc_we_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_unit #(.NSRC(NSRC), .REQ_LAG(2)) u0 (
    .clk(clk), .rst_n(rst_n), .flag_set_i(flag_set_i), .flag_clr_i(flag_clr_i),
    .src_en_i(src_en_i), .int_en_i(int_en_i), .swi_i(swi_i), .take_i(take_i),
    .pc_i(pc_i), .ret_i(ret_i), .ret_upd_i(ret_upd_i), .ret_pc_i(ret_pc_i),
    .vec_hi_we_i(vec_hi_we_i), .vec_lo_we_i(vec_lo_we_i), .vec_wdata_i(vec_wdata_i),
    .irq_o(irq_o), .gie_o(gie_o), .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o),
    .ipc_hi_o(ipc_hi_o), .ipc_lo_o(ipc_lo_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance one edge; inputs are driven and outputs sampled 1 unit after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_take(input logic [15:0] pc, input logic [15:0] exp_vec, input string req);
    take_i = 1'b1; pc_i = pc; #1;
    chk({req, " pc_we on take"}, 32'(pc_we_o), 1);
    chk({req, " vector on take"}, 32'(pc_wdata_o), 32'(exp_vec));
    step();
    take_i = 1'b0;
    chk("R5 saved pc", {16'h0, ipc_hi_o, ipc_lo_o}, 32'(pc));
    chk("R5 gie cleared", 32'(gie_o), 0);
  endtask

  task automatic do_ret(input logic upd, input logic [15:0] rpc);
    ret_i = 1'b1; ret_upd_i = upd; ret_pc_i = rpc;
    step();
    ret_i = 1'b0; ret_upd_i = 1'b0;
    chk("R6 gie restored", 32'(gie_o), 1);
  endtask

  task automatic t_reset();
    chk("R10 irq after reset", 32'(irq_o), 0);
    chk("R10 gie after reset", 32'(gie_o), 1);
    chk("R10 saved pc after reset", {16'h0, ipc_hi_o, ipc_lo_o}, 0);
    swi_i = 1'b1; take_i = 1'b1; #1;
    chk("R10 vector after reset", 32'(pc_wdata_o), 0);
    swi_i = 1'b0; take_i = 1'b0; #1;
  endtask

  task automatic t_lag();
    flag_set_i = 8'h01; step(); flag_set_i = '0;
    chk("R3 irq low after edge 1", 32'(irq_o), 0);
    step(); chk("R3 irq low after edge 2", 32'(irq_o), 0);
    step(); chk("R3 irq high after edge 3", 32'(irq_o), 1);
    step(); step(); step();
    chk("R1 flag held without clear", 32'(irq_o), 1);
    flag_clr_i = 8'h01; step(); flag_clr_i = '0;
    chk("R3 irq high 1 after clear", 32'(irq_o), 1);
    step(); chk("R3 irq high 2 after clear", 32'(irq_o), 1);
    step(); chk("R3 irq low 3 after clear", 32'(irq_o), 0);
  endtask

  task automatic t_mask();
    src_en_i = 8'hFE;
    flag_set_i = 8'h01; step(); flag_set_i = '0;
    step(); step(); step();
    chk("R2 disabled source ignored", 32'(irq_o), 0);
    src_en_i = 8'hFF; step(); step();
    chk("R2 source enabled later", 32'(irq_o), 1);
    int_en_i = 1'b0; #1;
    chk("R2 overall enable gates", 32'(irq_o), 0);
    int_en_i = 1'b1;
    flag_clr_i = 8'h01; step(); flag_clr_i = '0; step(); step();
    chk("R2 cleared", 32'(irq_o), 0);
  endtask

  task automatic t_setclr();
    flag_set_i = 8'h08; flag_clr_i = 8'h08; step();
    flag_set_i = '0; flag_clr_i = '0; step(); step();
    chk("R1 set wins over clear", 32'(irq_o), 1);
    flag_clr_i = 8'h08; step(); flag_clr_i = '0; step(); step();
  endtask

  task automatic t_swi();
    swi_i = 1'b1; #1;
    chk("R4 swi immediate", 32'(irq_o), 1);
    int_en_i = 1'b0; #1;
    chk("R4 swi gated", 32'(irq_o), 0);
    int_en_i = 1'b1; swi_i = 1'b0; #1;
  endtask

  task automatic t_take_ret();
    vec_hi_we_i = 1'b1; vec_wdata_i = 8'h12; step(); vec_hi_we_i = 1'b0;
    vec_lo_we_i = 1'b1; vec_wdata_i = 8'h34; step(); vec_lo_we_i = 1'b0;
    flag_set_i = 8'h02; step(); flag_set_i = '0; step(); step();
    do_take(16'hABCD, 16'h1234, "R8");
    chk("R5 irq masked after take", 32'(irq_o), 0);
    ret_i = 1'b1; #1;
    chk("R6 saved pc on return", 32'(pc_wdata_o), 32'hABCD);
    chk("R6 pc_we on return", 32'(pc_we_o), 1);
    step(); ret_i = 1'b0;
    chk("R9 pending request retaken", 32'(irq_o), 1);
    flag_clr_i = 8'h02; step(); flag_clr_i = '0; step(); step();
  endtask

  task automatic t_round_robin();
    do_take(16'h0200, 16'h1234, "R5");
    do_ret(1'b1, 16'h0050);
    do_take(16'h0300, 16'h0051, "R7");
    do_ret(1'b1, 16'hFFFF);
    do_take(16'h0400, 16'h0000, "R7 wrap");
    do_ret(1'b0, 16'h0000);
  endtask

  task automatic t_collide();
    do_take(16'h0500, 16'h0000, "R5");
    vec_hi_we_i = 1'b1; vec_wdata_i = 8'h77;
    do_ret(1'b1, 16'h4000);
    vec_hi_we_i = 1'b0;
    do_take(16'h0600, 16'h4001, "R8 return beats byte write");
    do_ret(1'b0, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flag_set_i = '0; flag_clr_i = '0; src_en_i = 8'hFF;
    int_en_i = 1'b1; swi_i = 1'b0; take_i = 1'b0; pc_i = '0;
    ret_i = 1'b0; ret_upd_i = 1'b0; ret_pc_i = '0;
    vec_hi_we_i = 1'b0; vec_lo_we_i = 1'b0; vec_wdata_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_lag();
    t_mask();
    t_setclr();
    t_swi();
    t_take_ret();
    t_round_robin();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule